// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic core that sits behind an 8-bit accumulator. A single strobe, `start`, applies one operation, chosen by `opSel`, to the accumulator and an 8-bit operand. Most operations finish on that clock edge, updating the accumulator and the flags (zero, subtract, half-carry, carry), which are read back as one packed byte. The half-carry is always taken from the low nibble. A decimal-adjust operation corrects the accumulator to packed BCD, with separate rules for after an addition and after a subtraction.

The block also offers a 16-bit add of two register-pair values. It runs as two byte additions on consecutive cycles, so it holds `busy` high for two cycles. During that time it ignores new strobes. Operand fetching, register routing and instruction decoding are done outside the block.

Top module: `bcd_acc_alu`

## Requirements
- R1: After reset, `accOut` is 0x00, `flagsOut` is 0x00, `pairSum` is 0x0000 and `busy` is 0.
- R2: Op 0 (add) and op 1 (add with carry, which also adds the old C) write the 8-bit sum to the accumulator. They clear N. H is the carry out of bit 3, C is the carry out of bit 7, and Z is set when the 8-bit sum is zero.
- R3: Op 2 (subtract) and op 3 (subtract with borrow, which also subtracts the old C) write the 8-bit difference to the accumulator. They set N. H is the borrow from the low nibble, C is the borrow out of bit 7, and Z is set when the difference is zero.
- R4: Op 4 (compare) sets Z, N, H and C exactly as op 2 would, and leaves the accumulator unchanged.
- R5: Ops 5 (AND), 6 (OR) and 7 (XOR) write the bitwise result to the accumulator. They clear N and C and set Z from the result. AND sets H to 1; OR and XOR clear H.
- R6: Op 8 adds 1 to the accumulator and clears N; H is set when the old low nibble was 0xF. Op 9 subtracts 1 from the accumulator and sets N; H is set when the old low nibble was 0x0. Both set Z from the result and leave C unchanged.
- R7: Op 10 (decimal adjust) with N clear first adds 0x06 if the low nibble is above 9 or H is set. It then adds 0x60 and sets C if bits 8:4 of that 9-bit partial sum exceed 9 or the old C was set; otherwise it clears C.
- R8: Op 10 with N set adds 0xFA if H is set and 0xA0 if C is set, modulo 256, and keeps C. In both decimal-adjust cases H is cleared, N is kept, and Z follows the result.
- R9: Op 11 inverts the accumulator and sets H and N. Op 12 sets C. Op 13 toggles C. Ops 12 and 13 clear H and N and keep Z and the accumulator.
- R10: Op 14 (pair add) raises `busy` for exactly two cycles. On completion, `pairSum` = (`pairBase` + `pairAddend`) mod 65536. N is cleared, H is the carry out of bit 11, C is the carry out of bit 15, and Z and the accumulator are unchanged.
- R11: A `start` strobe arriving while `busy` is high has no effect.
- R12: `flagsOut` packs Z at bit 7, N at bit 6, H at bit 5 and C at bit 4; bits 3:0 always read 0.
- R13: Op 15 changes neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Apply `opSel` on this edge |
| opSel | input | 4 | Operation code (see requirements) |
| operand | input | 8 | Second byte operand |
| pairBase | input | 16 | Pair-add first addend, held while busy |
| pairAddend | input | 16 | Pair-add second addend, held while busy |
| accOut | output | 8 | Accumulator |
| flagsOut | output | 8 | Packed flag byte |
| pairSum | output | 16 | Result of the last pair add |
| busy | output | 1 | Pair add in progress |

## Verification
The sweeps aim at the nibble boundaries, where a half-carry taken from the wrong bit, or one that ignores the incoming carry, shows up as a wrong H on add-with-carry and subtract-with-borrow. Decimal adjust is run after real additions and subtractions, so all combinations of H, C and N reach it. A design that merged the two branches, or dropped the 0x60 correction from the decision on the partial sum, returns a wrong digit or carry. The pair add is fed values whose low bytes carry into the high byte, and it is hit with a stray strobe while busy. A lost inter-byte carry, a disturbed Z or a strobe that slips through all corrupt the result that is compared.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int PAIR_W = 2 * DATA_W;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_CMP  = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_INC  = 4'd8,  OP_DEC = 4'd9,  OP_DAA = 4'd10, OP_CPL = 4'd11,
    OP_SCF  = 4'd12, OP_CCF = 4'd13, OP_PADD = 4'd14, OP_NOP = 4'd15
  } aluOp_t;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  typedef struct packed {
    logic byteOp;
    logic pairLo;
    logic pairHi;
  } ctlStrobe_t;
endpackage

// File: rtl/accAluCore.sv
`timescale 1ns/1ps
module accAluCore
  import acc_alu_pkg::*;
(
  input  aluOp_t            op,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  flags_t            flagsIn,
  output logic [DATA_W-1:0] accNew,
  output flags_t            flagsNew,
  output logic              writeAcc
);
  logic              carryIn;
  logic [DATA_W:0]   addSum, subDiff, daaUp;
  logic [NIB_W:0]    addNib, subNib;
  logic              daaUpCarry;
  logic [DATA_W-1:0] daaDown;

  always_comb begin
    carryIn = ((op == OP_ADC) || (op == OP_SBC)) && flagsIn.c;
    addSum  = {1'b0, accIn} + {1'b0, operand} + (DATA_W+1)'(carryIn);
    addNib  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, operand[NIB_W-1:0]} + (NIB_W+1)'(carryIn);
    subDiff = {1'b0, accIn} - {1'b0, operand} - (DATA_W+1)'(carryIn);
    subNib  = {1'b0, accIn[NIB_W-1:0]} - {1'b0, operand[NIB_W-1:0]} - (NIB_W+1)'(carryIn);
  end

  // decimal correction, additive and subtractive branches
  always_comb begin
    daaUp = {1'b0, accIn};
    if ((accIn[NIB_W-1:0] > 4'd9) || flagsIn.h)
      daaUp = daaUp + 9'h006;
    daaUpCarry = (daaUp[DATA_W:NIB_W] > 5'd9) || flagsIn.c;
    if (daaUpCarry)
      daaUp = daaUp + 9'h060;
    daaDown = accIn + (flagsIn.h ? 8'hFA : 8'h00) + (flagsIn.c ? 8'hA0 : 8'h00);
  end

  always_comb begin
    accNew   = accIn;
    flagsNew = flagsIn;
    writeAcc = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        accNew     = addSum[DATA_W-1:0];
        flagsNew.n = 1'b0;
        flagsNew.h = addNib[NIB_W];
        flagsNew.c = addSum[DATA_W];
        flagsNew.z = (accNew == '0);
        writeAcc   = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        accNew     = subDiff[DATA_W-1:0];
        flagsNew.n = 1'b1;
        flagsNew.h = subNib[NIB_W];
        flagsNew.c = subDiff[DATA_W];
        flagsNew.z = (accNew == '0);
        writeAcc   = (op != OP_CMP);
      end
      OP_AND, OP_OR, OP_XOR: begin
        accNew     = (op == OP_AND) ? (accIn & operand) :
                     (op == OP_OR)  ? (accIn | operand) : (accIn ^ operand);
        flagsNew.n = 1'b0;
        flagsNew.h = (op == OP_AND);
        flagsNew.c = 1'b0;
        flagsNew.z = (accNew == '0);
        writeAcc   = 1'b1;
      end
      OP_INC: begin
        accNew     = accIn + 8'd1;
        flagsNew.n = 1'b0;
        flagsNew.h = (accIn[NIB_W-1:0] == 4'hF);
        flagsNew.z = (accNew == '0);
        writeAcc   = 1'b1;
      end
      OP_DEC: begin
        accNew     = accIn - 8'd1;
        flagsNew.n = 1'b1;
        flagsNew.h = (accIn[NIB_W-1:0] == 4'h0);
        flagsNew.z = (accNew == '0);
        writeAcc   = 1'b1;
      end
      OP_DAA: begin
        accNew     = flagsIn.n ? daaDown : daaUp[DATA_W-1:0];
        flagsNew.c = flagsIn.n ? flagsIn.c : daaUpCarry;
        flagsNew.h = 1'b0;
        flagsNew.z = (accNew == '0);
        writeAcc   = 1'b1;
      end
      OP_CPL: begin
        accNew     = ~accIn;
        flagsNew.n = 1'b1;
        flagsNew.h = 1'b1;
        writeAcc   = 1'b1;
      end
      OP_SCF, OP_CCF: begin
        flagsNew.c = (op == OP_SCF) ? 1'b1 : ~flagsIn.c;
        flagsNew.n = 1'b0;
        flagsNew.h = 1'b0;
      end
      default: begin
        accNew   = accIn;
        flagsNew = flagsIn;
      end
    endcase
  end
endmodule

// File: rtl/accDatapath.sv
`timescale 1ns/1ps
module accDatapath
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  aluOp_t            op,
  input  logic [DATA_W-1:0] operand,
  input  logic [PAIR_W-1:0] pairBase,
  input  logic [PAIR_W-1:0] pairAddend,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagByte,
  output logic [PAIR_W-1:0] pairSum
);
  logic [DATA_W-1:0] accReg, accNew;
  flags_t            flagReg, flagsNew;
  logic              writeAcc;
  logic [PAIR_W-1:0] pairReg;
  logic              pairCarry;
  logic [DATA_W:0]   loSum, hiSum;
  logic [NIB_W:0]    hiNib;

  accAluCore uCore (
    .op       (op),
    .accIn    (accReg),
    .operand  (operand),
    .flagsIn  (flagReg),
    .accNew   (accNew),
    .flagsNew (flagsNew),
    .writeAcc (writeAcc)
  );

  always_comb begin
    loSum = {1'b0, pairBase[DATA_W-1:0]} + {1'b0, pairAddend[DATA_W-1:0]};
    hiSum = {1'b0, pairBase[PAIR_W-1:DATA_W]} + {1'b0, pairAddend[PAIR_W-1:DATA_W]}
            + (DATA_W+1)'(pairCarry);
    hiNib = {1'b0, pairBase[DATA_W+NIB_W-1:DATA_W]} + {1'b0, pairAddend[DATA_W+NIB_W-1:DATA_W]}
            + (NIB_W+1)'(pairCarry);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg    <= '0;
      flagReg   <= '0;
      pairReg   <= '0;
      pairCarry <= 1'b0;
    end else begin
      if (ctl.byteOp) begin
        if (writeAcc) accReg <= accNew;
        flagReg <= flagsNew;
      end
      if (ctl.pairLo) begin
        pairReg[DATA_W-1:0] <= loSum[DATA_W-1:0];
        pairCarry           <= loSum[DATA_W];
      end
      if (ctl.pairHi) begin
        pairReg[PAIR_W-1:DATA_W] <= hiSum[DATA_W-1:0];
        flagReg.n <= 1'b0;
        flagReg.h <= hiNib[NIB_W];
        flagReg.c <= hiSum[DATA_W];
      end
    end
  end

  assign accOut   = accReg;
  assign flagByte = {flagReg.z, flagReg.n, flagReg.h, flagReg.c, {(DATA_W-NIB_W){1'b0}}};
  assign pairSum  = pairReg;
endmodule

// File: rtl/accControl.sv
`timescale 1ns/1ps
module accControl
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  aluOp_t     op,
  output ctlStrobe_t ctl,
  output logic       busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} ctlState_t;
  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start && (op == OP_PADD)) stateNext = ST_LO;
      ST_LO:   stateNext = ST_HI;
      ST_HI:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl        = '0;
    ctl.byteOp = (state == ST_IDLE) && start && (op != OP_PADD);
    ctl.pairLo = (state == ST_LO);
    ctl.pairHi = (state == ST_HI);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bcd_acc_alu.sv
`timescale 1ns/1ps
module bcd_acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] operand,
  input  logic [PAIR_W-1:0] pairBase,
  input  logic [PAIR_W-1:0] pairAddend,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic [PAIR_W-1:0] pairSum,
  output logic              busy
);
  aluOp_t     opCode;
  ctlStrobe_t ctl;

  assign opCode = aluOp_t'(opSel);

  accControl uCtl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .op    (opCode),
    .ctl   (ctl),
    .busy  (busy)
  );

  accDatapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .op         (opCode),
    .operand    (operand),
    .pairBase   (pairBase),
    .pairAddend (pairAddend),
    .accOut     (accOut),
    .flagByte   (flagsOut),
    .pairSum    (pairSum)
  );
endmodule

// File: rtl/accAluChecker.sv
`timescale 1ns/1ps
module accAluChecker
  import acc_alu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [OP_W-1:0]   opSel,
  input logic              busy,
  input logic [DATA_W-1:0] accOut,
  input logic [DATA_W-1:0] flagsOut
);
  logic issue;
  assign issue = start && !busy;

  assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rstN)
    issue && (opSel == OP_CMP) |=> $stable(accOut));

  assert_and_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    issue && (opSel == OP_AND) |=> flagsOut[5] && !flagsOut[6] && !flagsOut[4]);

  assert_incdec_keep_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    issue && ((opSel == OP_INC) || (opSel == OP_DEC)) |=> flagsOut[4] == $past(flagsOut[4]));

  assert_scf_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    issue && (opSel == OP_SCF) |=> flagsOut[4] && !flagsOut[5] && !flagsOut[6]);

  assert_ccf_toggles_R9: assert property (@(posedge clk) disable iff (!rstN)
    issue && (opSel == OP_CCF) |=> flagsOut[4] != $past(flagsOut[4]));

  assert_pair_two_cycles_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  assert_pair_keeps_acc_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(accOut));

  assert_nop_no_change_R13: assert property (@(posedge clk) disable iff (!rstN)
    issue && (opSel == OP_NOP) |=> $stable(accOut) && $stable(flagsOut));
endmodule

bind bcd_acc_alu accAluChecker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .opSel    (opSel),
  .busy     (busy),
  .accOut   (accOut),
  .flagsOut (flagsOut)
);

// File: tb/sim_bcd_acc_alu.sv
`timescale 1ns/1ps
module sim_bcd_acc_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opSel = 4'd15;
  logic [7:0]  operand = 8'd0;
  logic [15:0] pairBase = 16'd0;
  logic [15:0] pairAddend = 16'd0;
  logic [7:0]  accOut;
  logic [7:0]  flagsOut;
  logic [15:0] pairSum;
  logic        busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int mA = 0, mZ = 0, mN = 0, mH = 0, mC = 0;

  always #4 clk = ~clk;

  bcd_acc_alu u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .operand(operand),
    .pairBase(pairBase), .pairAddend(pairAddend), .accOut(accOut),
    .flagsOut(flagsOut), .pairSum(pairSum), .busy(busy)
  );

  function automatic int packF();
    return (mZ << 7) | (mN << 6) | (mH << 5) | (mC << 4);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic modelOp(input int op, input int b);
    int a, r, ci;
    a = mA;
    case (op)
      0, 1: begin
        ci = (op == 1) ? mC : 0;
        r = a + b + ci;
        mH = (((a & 15) + (b & 15) + ci) > 15);
        mC = (r > 255); mA = r & 255; mZ = (mA == 0); mN = 0;
      end
      2, 3, 4: begin
        ci = (op == 3) ? mC : 0;
        r = a - b - ci;
        mH = (((a & 15) - (b & 15) - ci) < 0);
        mC = (r < 0); mZ = ((r & 255) == 0); mN = 1;
        if (op != 4) mA = r & 255;
      end
      5: begin mA = a & b; mZ = (mA == 0); mN = 0; mH = 1; mC = 0; end
      6: begin mA = a | b; mZ = (mA == 0); mN = 0; mH = 0; mC = 0; end
      7: begin mA = a ^ b; mZ = (mA == 0); mN = 0; mH = 0; mC = 0; end
      8: begin mH = ((a & 15) == 15); mA = (a + 1) & 255; mZ = (mA == 0); mN = 0; end
      9: begin mH = ((a & 15) == 0); mA = (a - 1) & 255; mZ = (mA == 0); mN = 1; end
      10: begin
        r = a;
        if (mN == 0) begin
          if (((a & 15) > 9) || (mH != 0)) r = r + 6;
          if (((r & 'h1F0) > 'h90) || (mC != 0)) begin r = r + 'h60; mC = 1; end
          else mC = 0;
        end else begin
          if (mH != 0) r = r + 'hFA;
          if (mC != 0) r = r + 'hA0;
        end
        mA = r & 255; mH = 0; mZ = (mA == 0);
      end
      11: begin mA = a ^ 255; mH = 1; mN = 1; end
      12: begin mC = 1; mH = 0; mN = 0; end
      13: begin mC = 1 - mC; mH = 0; mN = 0; end
      default: ;
    endcase
  endtask

  // one byte operation: drive at negedge, result visible after the next posedge
  task automatic runOp(input int op, input int b, input string tag);
    modelOp(op, b);
    start = 1'b1; opSel = 4'(op); operand = 8'(b);
    @(posedge clk); @(negedge clk);
    start = 1'b0; opSel = 4'd15;
    check(tag, {accOut, flagsOut}, (mA << 8) | packF());
  endtask

  task automatic loadAcc(input int a);
    runOp(5, 0, "R5 clear");
    runOp(6, a, "R5 load");
  endtask

  task automatic setCarry(input int c);
    runOp(12, 0, "R9 scf");
    if (c == 0) runOp(13, 0, "R9 ccf");
  endtask

  task automatic runPair(input int base, input int add);
    int lo, cl, hi, hh, sum;
    pairBase = 16'(base); pairAddend = 16'(add);
    start = 1'b1; opSel = 4'd14;
    @(posedge clk); @(negedge clk);
    check("R10 busy first cycle", busy, 1);
    start = 1'b1; opSel = 4'd11;          // stray strobe, must be ignored (R11)
    @(posedge clk); @(negedge clk);
    start = 1'b0; opSel = 4'd15;
    check("R10 busy second cycle", busy, 1);
    @(posedge clk); @(negedge clk);
    lo = (base & 255) + (add & 255);
    cl = (lo > 255) ? 1 : 0;
    hi = ((base >> 8) & 255) + ((add >> 8) & 255) + cl;
    hh = ((((base >> 8) & 15) + ((add >> 8) & 15) + cl) > 15) ? 1 : 0;
    sum = (base + add) & 16'hFFFF;
    mN = 0; mH = hh; mC = (hi > 255) ? 1 : 0;
    check("R10 busy released", busy, 0);
    check("R10 pair sum", pairSum, sum);
    check("R11 acc and flags after pair", {accOut, flagsOut}, (mA << 8) | packF());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc reset", accOut, 0);
    check("R1 flags reset", flagsOut, 0);
    check("R1 pair reset", pairSum, 0);
    check("R1 busy reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R12 packing on fixed patterns
    runOp(12, 0, "R12 carry bit4");
    runOp(11, 0, "R12 h n bits");
    runOp(5, 0, "R12 z h bits");
    runOp(15, 'h5A, "R13 nop");

    // R2 R3 R4 arithmetic sweep
    for (int op = 0; op <= 4; op++)
      for (int a = 0; a < 256; a += 3)
        for (int b = 0; b < 256; b += 17)
          for (int c = 0; c < 2; c++) begin
            loadAcc(a);
            setCarry(c);
            runOp(op, b, (op < 2) ? "R2 add" : (op == 4) ? "R4 compare" : "R3 sub");
          end

    // R5 logic
    for (int op = 5; op <= 7; op++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 7) begin
          loadAcc(a);
          runOp(op, b, "R5 logic");
        end

    // R6 inc/dec, carry kept
    for (int op = 8; op <= 9; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++) begin
          loadAcc(a);
          setCarry(c);
          runOp(op, 'hFF, "R6 incdec");
        end

    // R7 R8 decimal adjust after add and after subtract
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 11)
        for (int c = 0; c < 2; c++) begin
          loadAcc(a); setCarry(c);
          runOp(1, b, "R7 pre add");
          runOp(10, 0, "R7 daa after add");
          loadAcc(a); setCarry(c);
          runOp(3, b, "R8 pre sub");
          runOp(10, 0, "R8 daa after sub");
        end

    // R9 complement, R13 nop on varied state
    for (int a = 0; a < 256; a += 3) begin
      loadAcc(a);
      runOp(11, 0, "R9 cpl");
      runOp(13, 0, "R9 ccf");
      runOp(15, a, "R13 nop");
    end

    // R10 R11 pair add, Z kept from both states
    for (int i = 0; i < 40; i++)
      for (int j = 0; j < 10; j++) begin
        loadAcc((i & 1) ? 0 : 'h3C);
        runPair((i * 1637 + 'h0FF0) & 16'hFFFF, (j * 7919 + 'h00F1) & 16'hFFFF);
      end
    runPair('hFFFF, 'h0001);
    runPair('h0FFF, 'h0001);
    runPair('h8000, 'h8000);

    finish();
  end
endmodule